// File: doc/BRIEF.md
# Power State Sequencer

This block is the finite-state controller that moves a system between its processor idle levels and its system sleep levels. While the system runs, it can halt the processor. It can also stop the processor clock through a request and acknowledge exchange, and after that exchange it can put the processor to sleep. Software enters a sleep level by setting a sleep-enable strobe together with a three-bit sleep type. Each sleep level then removes a different set of power rails. A power-button override goes straight to soft off, and a power-fail input overrides everything.

In the running state the block can also throttle the processor. It gates the stop-clock request on for a fixed fraction of a repeating period, whenever a software enable or a thermal input is high. Break or wake events bring the system back to the running state. Along the way, the sleep request is always dropped a fixed number of clocks before the stop-clock request. The block does not generate clocks, run refresh or keep time: it only reports their status.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, `state_o` reads 0 (running). The stop-clock and sleep requests are low, both power rails are on, and coherency is reported.
- R2: A halt strobe in state 0 moves to state 1 (halted) on the next clock. State 1 drives no stop-clock request and reports coherency. A break or wake returns it to state 0.
- R3: A level-2 read strobe in state 0 moves to state 2 on the next clock and raises the stop-clock request. The sleep request stays low in state 2, even after the acknowledge.
- R4: A level-3 read strobe in state 0 moves to state 3 and raises the stop-clock request. Sleep is raised only on the clock after an acknowledge has been sampled in state 3. State 3 reports coherency lost.
- R5: In state 0, a sleep-enable strobe with sleep type 1, 3, 4 or 5 enters state 4, 5, 6 or 7 respectively. With any other type the block stays in state 0.
- R6: State 4 (light sleep) raises the stop-clock request and keeps both rails on. After the acknowledge, sleep follows the sleep-configuration input.
- R7: State 5 (suspend to memory) turns off the non-critical rail and keeps the memory rail on. It reports clocks stopped and refresh valid.
- R8: States 6 and 7 turn off both the non-critical rail and the memory rail.
- R9: A power-button override in state 0 enters state 7. A power-fail input enters state 8 (mechanical off) from any state, with both rails off. State 8 is held while power-fail stays high.
- R10: In state 0, while the throttle enable or the thermal input is high, the stop-clock request is high for the first 2 of every 8 clocks. This starts on the clock after the enable.
- R11: A break or wake in states 2, 3, 4 or 5 goes through exit state 9. There, sleep is low and the stop-clock request stays high for exactly 2 clocks before state 0. A break alone has no effect in states 6 and 7.
- R12: A wake in state 6, 7 or 8 (with power-fail low) returns to state 0. It raises `full_boot_o` for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_i | input | 1 | Processor halt indication |
| stpgnt_ack_i | input | 1 | Stop-Grant acknowledge from processor |
| lvl2_rd_i | input | 1 | Level-2 read strobe |
| lvl3_rd_i | input | 1 | Level-3 read strobe |
| slp_en_i | input | 1 | Software sleep-enable strobe |
| slp_typ_i | input | 3 | Sleep type (1,3,4,5 valid) |
| s1_slp_cfg_i | input | 1 | Allow processor sleep in light sleep |
| pbtn_ovr_i | input | 1 | Power-button override |
| thr_en_i | input | 1 | Software throttle enable |
| thrm_i | input | 1 | Thermal throttle request |
| pwr_fail_i | input | 1 | Power failure / mechanical off |
| brk_evt_i | input | 1 | Break event |
| wake_evt_i | input | 1 | Wake event |
| state_o | output | 4 | Current state code |
| stpclk_o | output | 1 | Processor stop-clock request |
| sleep_o | output | 1 | Processor sleep request |
| noncrit_pwr_en_o | output | 1 | Non-critical rail enable |
| mem_pwr_en_o | output | 1 | Memory-subsystem rail enable |
| coherent_o | output | 1 | Cache coherency maintained |
| clocks_stopped_o | output | 1 | All clocks except time-keeping stopped |
| refresh_ok_o | output | 1 | Memory refresh valid |
| full_boot_o | output | 1 | One-clock pulse: full resume/boot needed |

## Verification
A wrong state register shows on `state_o` and on the rail and request outputs on the clock right after the triggering strobe. Each step of the bench therefore samples half a clock after that edge. A lost acknowledge flag shows as sleep rising too early or never rising. A wrong exit counter changes the number of clocks between the fall of sleep and the fall of stop-clock, so the bench measures that interval directly. Throttle counter faults show within one 8-clock period of the stop-clock pattern.

// File: rtl/pwr_seq_pkg.sv
// Shared state encoding and sleep-type decode for the power sequencer.
// Assumes a 3-bit sleep type where only 1, 3, 4 and 5 are meaningful.
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        PS_C0   = 4'd0,
        PS_C1   = 4'd1,
        PS_C2   = 4'd2,
        PS_C3   = 4'd3,
        PS_S1   = 4'd4,
        PS_S3   = 4'd5,
        PS_S4   = 4'd6,
        PS_S5   = 4'd7,
        PS_G3   = 4'd8,
        PS_EXIT = 4'd9
    } pstate_e;

    // Whether a sleep type selects a real sleep level.
    function automatic logic slp_type_ok(input logic [2:0] t);
        return (t == 3'd1) || (t == 3'd3) || (t == 3'd4) || (t == 3'd5);
    endfunction

    // Target state for a valid sleep type.
    function automatic pstate_e slp_target(input logic [2:0] t);
        pstate_e r;
        case (t)
            3'd1:    r = PS_S1;
            3'd3:    r = PS_S3;
            3'd4:    r = PS_S4;
            3'd5:    r = PS_S5;
            default: r = PS_C0;
        endcase
        return r;
    endfunction

    // States in which the processor clock is held stopped by handshake.
    function automatic logic is_hs_state(input pstate_e s);
        return (s == PS_C2) || (s == PS_C3) || (s == PS_S1);
    endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
// State register, transition rules, Stop-Grant acknowledge flag, exit
// spacing counter and full-boot pulse. Assumes strobes are synchronous.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int EXIT_GAP = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt_i,
    input  logic    ack_i,
    input  logic    lvl2_i,
    input  logic    lvl3_i,
    input  logic    slp_en_i,
    input  logic [2:0] slp_typ_i,
    input  logic    pbtn_i,
    input  logic    pfail_i,
    input  logic    brk_i,
    input  logic    wake_i,
    output pstate_e state_o,
    output logic    acked_o,
    output logic    boot_o
);
    localparam int GW = (EXIT_GAP > 1) ? $clog2(EXIT_GAP + 1) : 1;

    pstate_e       state_q, nxt;
    logic          acked_q, boot_q;
    logic [GW-1:0] gap_cnt;
    logic          gap_done;

    assign gap_done = (gap_cnt == GW'(EXIT_GAP - 1));

    // Next-state selection with power-fail as highest priority.
    always_comb begin
        nxt = state_q;
        if (pfail_i) begin
            nxt = PS_G3;
        end else begin
            case (state_q)
                PS_C0: begin
                    if (pbtn_i)                             nxt = PS_S5;
                    else if (slp_en_i && slp_type_ok(slp_typ_i)) nxt = slp_target(slp_typ_i);
                    else if (lvl3_i)                        nxt = PS_C3;
                    else if (lvl2_i)                        nxt = PS_C2;
                    else if (halt_i)                        nxt = PS_C1;
                end
                PS_C1: if (brk_i || wake_i) nxt = PS_C0;
                PS_C2, PS_C3, PS_S1, PS_S3: if (brk_i || wake_i) nxt = PS_EXIT;
                PS_S4, PS_S5, PS_G3: if (wake_i) nxt = PS_C0;
                PS_EXIT: if (gap_done) nxt = PS_C0;
                default: nxt = PS_C0;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_C0;
        else        state_q <= nxt;
    end

    // Acknowledge flag: cleared on any state change, set by ack in handshake states.
    always_ff @(posedge clk) begin
        if (!rst_n)                              acked_q <= 1'b0;
        else if (nxt != state_q)                 acked_q <= 1'b0;
        else if (is_hs_state(state_q) && ack_i)  acked_q <= 1'b1;
    end

    // Exit spacing counter, running only in the exit state.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != PS_EXIT) gap_cnt <= '0;
        else                              gap_cnt <= gap_cnt + 1'b1;
    end

    // One-clock full-boot pulse on leaving a context-losing state.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_q <= 1'b0;
        else        boot_q <= (state_q == PS_S4 || state_q == PS_S5 || state_q == PS_G3)
                              && (nxt == PS_C0);
    end

    assign state_o = state_q;
    assign acked_o = acked_q;
    assign boot_o  = boot_q;
endmodule

// File: rtl/pwr_seq_throttle.sv
// Periodic stop-clock pulse generator for the running state.
// Assumes ON_CYC < PERIOD; restarts its phase each time it is enabled.
module pwr_seq_throttle #(
    parameter int PERIOD = 8,
    parameter int ON_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_run_i,
    input  logic req_i,
    output logic pulse_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic          act_q;
    logic [CW-1:0] cnt;

    // Register the throttle request, qualified by the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= in_run_i && req_i;
    end

    // Phase counter, wrapping at PERIOD while active.
    always_ff @(posedge clk) begin
        if (!rst_n || !act_q)            cnt <= '0;
        else if (cnt == CW'(PERIOD - 1)) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

    assign pulse_o = act_q && in_run_i && (cnt < CW'(ON_CYC));
endmodule

// File: rtl/pwr_seq_outdec.sv
// Decodes state and handshake status into processor requests, rail
// enables and status flags. Purely combinational.
module pwr_seq_outdec
    import pwr_seq_pkg::*;
(
    input  pstate_e state_i,
    input  logic    acked_i,
    input  logic    s1_slp_cfg_i,
    input  logic    thr_pulse_i,
    output logic    stpclk_o,
    output logic    sleep_o,
    output logic    noncrit_o,
    output logic    mem_o,
    output logic    coherent_o,
    output logic    clk_stop_o,
    output logic    refresh_o
);
    logic off_deep, off_mem;

    // Group the states that remove rails.
    always_comb begin
        off_mem  = (state_i == PS_S4) || (state_i == PS_S5) || (state_i == PS_G3);
        off_deep = off_mem || (state_i == PS_S3);
    end

    // Processor-facing requests.
    always_comb begin
        stpclk_o = is_hs_state(state_i) || (state_i == PS_S3) || (state_i == PS_EXIT)
                   || ((state_i == PS_C0) && thr_pulse_i);
        sleep_o  = ((state_i == PS_C3) && acked_i)
                   || ((state_i == PS_S1) && acked_i && s1_slp_cfg_i)
                   || (state_i == PS_S3);
    end

    // Rails and status reporting.
    always_comb begin
        noncrit_o  = !off_deep;
        mem_o      = !off_mem;
        clk_stop_o = off_deep;
        refresh_o  = !off_mem;
        coherent_o = (state_i == PS_C0) || (state_i == PS_C1)
                     || (state_i == PS_C2) || (state_i == PS_S1);
    end
endmodule

// File: rtl/pwr_seq_top.sv
// Power state sequencer top: ties the FSM, throttle generator and
// output decoder together. All inputs are assumed synchronous to clk.
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int EXIT_GAP   = 2,
    parameter int THR_PERIOD = 8,
    parameter int THR_ON     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_i,
    input  logic       stpgnt_ack_i,
    input  logic       lvl2_rd_i,
    input  logic       lvl3_rd_i,
    input  logic       slp_en_i,
    input  logic [2:0] slp_typ_i,
    input  logic       s1_slp_cfg_i,
    input  logic       pbtn_ovr_i,
    input  logic       thr_en_i,
    input  logic       thrm_i,
    input  logic       pwr_fail_i,
    input  logic       brk_evt_i,
    input  logic       wake_evt_i,
    output logic [3:0] state_o,
    output logic       stpclk_o,
    output logic       sleep_o,
    output logic       noncrit_pwr_en_o,
    output logic       mem_pwr_en_o,
    output logic       coherent_o,
    output logic       clocks_stopped_o,
    output logic       refresh_ok_o,
    output logic       full_boot_o
);
    pstate_e st;
    logic    acked, thr_pulse;

    pwr_seq_fsm #(.EXIT_GAP(EXIT_GAP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .ack_i(stpgnt_ack_i),
        .lvl2_i(lvl2_rd_i), .lvl3_i(lvl3_rd_i), .slp_en_i(slp_en_i),
        .slp_typ_i(slp_typ_i), .pbtn_i(pbtn_ovr_i), .pfail_i(pwr_fail_i),
        .brk_i(brk_evt_i), .wake_i(wake_evt_i),
        .state_o(st), .acked_o(acked), .boot_o(full_boot_o)
    );

    pwr_seq_throttle #(.PERIOD(THR_PERIOD), .ON_CYC(THR_ON)) u_thr (
        .clk(clk), .rst_n(rst_n), .in_run_i(st == PS_C0),
        .req_i(thr_en_i || thrm_i), .pulse_o(thr_pulse)
    );

    pwr_seq_outdec u_dec (
        .state_i(st), .acked_i(acked), .s1_slp_cfg_i(s1_slp_cfg_i),
        .thr_pulse_i(thr_pulse), .stpclk_o(stpclk_o), .sleep_o(sleep_o),
        .noncrit_o(noncrit_pwr_en_o), .mem_o(mem_pwr_en_o),
        .coherent_o(coherent_o), .clk_stop_o(clocks_stopped_o),
        .refresh_o(refresh_ok_o)
    );

    assign state_o = st;
endmodule

// File: rtl/pwr_seq_chk.sv
// Port-level protocol checks for pwr_seq_top, attached by bind below.
module pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_i,
    input logic       lvl2_rd_i,
    input logic       lvl3_rd_i,
    input logic       slp_en_i,
    input logic [2:0] slp_typ_i,
    input logic       pbtn_ovr_i,
    input logic       pwr_fail_i,
    input logic       wake_evt_i,
    input logic [3:0] state_o,
    input logic       stpclk_o,
    input logic       sleep_o,
    input logic       noncrit_pwr_en_o,
    input logic       mem_pwr_en_o,
    input logic       coherent_o
);
    logic [1:0] age;

    // Clocks since reset, saturating, to guard history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_halt_no_stpclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd1) |-> !stpclk_o);

    p_sleep_under_stpclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> stpclk_o);

    p_c3_incoherent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd3) |-> !coherent_o);

    p_bad_type_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0 && slp_en_i && !(slp_typ_i == 3'd1 || slp_typ_i == 3'd3 ||
         slp_typ_i == 3'd4 || slp_typ_i == 3'd5) && !halt_i && !lvl2_rd_i &&
         !lvl3_rd_i && !pbtn_ovr_i && !pwr_fail_i) |=> (state_o == 4'd0));

    p_rail_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pwr_en_o |-> !noncrit_pwr_en_o);

    p_pfail_moff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> (state_o == 4'd8));

    p_pbtn_soft_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0 && pbtn_ovr_i && !pwr_fail_i) |=> (state_o == 4'd7));

    p_sleep_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $fell(stpclk_o)) |-> (!$past(sleep_o) && !$past(sleep_o, 2)));

    p_deep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 4'd6 || state_o == 4'd7) && !wake_evt_i && !pwr_fail_i)
        |=> $stable(state_o));
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .lvl2_rd_i(lvl2_rd_i),
    .lvl3_rd_i(lvl3_rd_i), .slp_en_i(slp_en_i), .slp_typ_i(slp_typ_i),
    .pbtn_ovr_i(pbtn_ovr_i), .pwr_fail_i(pwr_fail_i), .wake_evt_i(wake_evt_i),
    .state_o(state_o), .stpclk_o(stpclk_o), .sleep_o(sleep_o),
    .noncrit_pwr_en_o(noncrit_pwr_en_o), .mem_pwr_en_o(mem_pwr_en_o),
    .coherent_o(coherent_o)
);

// File: tb/sim_pwr_seq_top.sv
// Self-checking bench: sweeps sleep types and configuration, walks each
// idle level in and out, and measures throttle and exit timing.
module sim_pwr_seq_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic halt = 0, ack = 0, lvl2 = 0, lvl3 = 0, slp_en = 0, s1cfg = 0;
    logic pbtn = 0, thr_en = 0, thrm = 0, pfail = 0, brk = 0, wake = 0;
    logic [2:0] slp_typ = 3'd0;
    logic [3:0] state;
    logic stpclk, sleep, noncrit, mem, coherent, clkstop, refresh, boot;

    int errs = 0;
    int checks = 0;

    pwr_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .stpgnt_ack_i(ack),
        .lvl2_rd_i(lvl2), .lvl3_rd_i(lvl3), .slp_en_i(slp_en), .slp_typ_i(slp_typ),
        .s1_slp_cfg_i(s1cfg), .pbtn_ovr_i(pbtn), .thr_en_i(thr_en), .thrm_i(thrm),
        .pwr_fail_i(pfail), .brk_evt_i(brk), .wake_evt_i(wake),
        .state_o(state), .stpclk_o(stpclk), .sleep_o(sleep),
        .noncrit_pwr_en_o(noncrit), .mem_pwr_en_o(mem), .coherent_o(coherent),
        .clocks_stopped_o(clkstop), .refresh_ok_o(refresh), .full_boot_o(boot)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        {halt, ack, lvl2, lvl3, slp_en, s1cfg, pbtn, thr_en, thrm, pfail, brk, wake} = '0;
        slp_typ = 3'd0;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int exp_st;
        int n;
        @(negedge clk);
        do_reset;
        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 stpclk", stpclk, 0);
        chk("R1 sleep", sleep, 0);
        chk("R1 rails", {noncrit, mem}, 3);
        chk("R1 coherent", coherent, 1);

        // R2 halt and return
        halt = 1; step; halt = 0;
        chk("R2 state", state, 1);
        chk("R2 stpclk", stpclk, 0);
        chk("R2 coherent", coherent, 1);
        brk = 1; step; brk = 0;
        chk("R2 return", state, 0);

        // R3 level-2 read
        lvl2 = 1; step; lvl2 = 0;
        chk("R3 state", state, 2);
        chk("R3 stpclk", stpclk, 1);
        ack = 1; step; ack = 0; step;
        chk("R3 no sleep after ack", sleep, 0);
        chk("R3 held", state, 2);
        wake = 1; step; wake = 0;
        chk("R11 exit state", state, 9);
        step(2);
        chk("R11 back to run", state, 0);
        chk("R11 stpclk released", stpclk, 0);

        // R4 level-3 read with handshake
        lvl3 = 1; step; lvl3 = 0;
        chk("R4 state", state, 3);
        chk("R4 stpclk", stpclk, 1);
        chk("R4 coherent lost", coherent, 0);
        step(2);
        chk("R4 no sleep before ack", sleep, 0);
        ack = 1; step; ack = 0;
        chk("R4 sleep after ack", sleep, 1);
        brk = 1; step; brk = 0;
        chk("R11 sleep dropped", sleep, 0);
        chk("R11 stpclk kept", stpclk, 1);
        n = 0;
        while (stpclk && n < 10) begin step; n++; end
        chk("R11 gap clocks", n, 2);
        chk("R11 state", state, 0);

        // R5..R8, R11, R12 sweep over every sleep type and config bit
        for (int t = 0; t < 8; t++) begin
            for (int c = 0; c < 2; c++) begin
                do_reset;
                s1cfg = c[0];
                slp_typ = t[2:0];
                slp_en = 1; step; slp_en = 0;
                exp_st = (t == 1) ? 4 : (t == 3) ? 5 : (t == 4) ? 6 : (t == 5) ? 7 : 0;
                chk("R5 target state", state, exp_st);
                if (exp_st == 0) begin
                    chk("R5 ignored rails", {noncrit, mem}, 3);
                    chk("R5 ignored stpclk", stpclk, 0);
                end else if (exp_st == 4) begin
                    chk("R6 stpclk", stpclk, 1);
                    chk("R6 sleep pre-ack", sleep, 0);
                    chk("R6 rails", {noncrit, mem}, 3);
                    chk("R6 coherent", coherent, 1);
                    ack = 1; step; ack = 0;
                    chk("R6 sleep per cfg", sleep, c);
                    brk = 1; step; brk = 0;
                    step(2);
                    chk("R11 light sleep exit", state, 0);
                end else if (exp_st == 5) begin
                    chk("R7 rails", {noncrit, mem}, 1);
                    chk("R7 clocks stopped", clkstop, 1);
                    chk("R7 refresh", refresh, 1);
                    wake = 1; step; wake = 0;
                    chk("R11 via exit", state, 9);
                    step(2);
                    chk("R11 suspend exit", state, 0);
                    chk("R11 rails restored", {noncrit, mem}, 3);
                end else begin
                    chk("R8 rails", {noncrit, mem}, 0);
                    brk = 1; step; brk = 0;
                    chk("R11 break ignored", state, exp_st);
                    chk("R11 break no boot", boot, 0);
                    wake = 1; step; wake = 0;
                    chk("R12 wake to run", state, 0);
                    chk("R12 boot pulse", boot, 1);
                    step;
                    chk("R12 boot pulse ends", boot, 0);
                end
            end
        end

        // R9 power-button override and power fail
        do_reset;
        pbtn = 1; step; pbtn = 0;
        chk("R9 override state", state, 7);
        chk("R9 override rails", {noncrit, mem}, 0);
        do_reset;
        lvl3 = 1; step; lvl3 = 0;
        pfail = 1; step;
        chk("R9 fail state", state, 8);
        chk("R9 fail rails", {noncrit, mem}, 0);
        wake = 1; step;
        chk("R9 fail held", state, 8);
        pfail = 0; wake = 0; step;
        chk("R9 stays off", state, 8);
        wake = 1; step; wake = 0;
        chk("R12 from off", state, 0);
        chk("R12 boot from off", boot, 1);

        // R10 throttle pattern via software enable, then thermal input
        for (int src = 0; src < 2; src++) begin
            do_reset;
            if (src == 0) thr_en = 1; else thrm = 1;
            for (int k = 0; k < 24; k++) begin
                step;
                chk("R10 throttle pattern", stpclk, ((k % 8) < 2) ? 1 : 0);
            end
            thr_en = 0; thrm = 0; step;
            chk("R10 throttle off", stpclk, 0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule